// File: doc/BRIEF.md
# System memory-map chip-select decoder

This block turns a 20-bit processor address and an active-low memory-request strobe into four active-low chip selects for a small system. The four devices are two 64K RAM banks at the bottom of the address space, a 16K video RAM and a 1K ROM at the very top. Only the ten high-order address bits take part in the decode. Each device decodes the lower ten bits itself.

The map is a 1024-entry by 4-bit pattern table indexed by address bits 19..10. The table is computed at elaboration from region parameters. Each table bit drives one select directly: bit 0 the ROM, bit 1 the video RAM, bit 2 RAM bank 1 and bit 3 RAM bank 0. A mode input enables incomplete decoding of the ROM. In that mode the ROM answers whenever index bits 7..0 match its own, so ghost copies of it appear in unmapped space.

The selects and an unmapped-access flag are registered, so they follow the address by exactly one clock.

Top module: `memmap_csel`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, all four selects are high and `unmapped` is low.
- R2: Every output reflects the address, strobe and mode sampled at the previous rising clock edge. It is not affected by input changes within the current cycle.
- R3: With the strobe low, addresses 0x00000 to 0x0FFFF drive only `ram0_cs_n` low.
- R4: With the strobe low, addresses 0x10000 to 0x1FFFF drive only `ram1_cs_n` low.
- R5: With the strobe low, addresses 0xB0000 to 0xB3FFF drive only `vram_cs_n` low.
- R6: With the strobe low, addresses 0xFFC00 to 0xFFFFF drive only `rom_cs_n` low.
- R7: With the strobe low and `ghost_en` low, any other address keeps all selects high and sets `unmapped` high.
- R8: With the strobe high, all selects are high and `unmapped` is low, whatever the address.
- R9: With `ghost_en` high and the strobe low, an address that lies in no device region and whose bits 17..10 are all ones (0x3FC00, 0x7FC00, 0xBFC00 blocks) drives only `rom_cs_n` low. Other unmapped addresses remain unmapped.
- R10: At most one select is low in any cycle, and `unmapped` is never high while a select is low.
- R11: `ghost_en` has no effect on addresses inside the four device regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 20 | Processor address |
| mreq_n | input | 1 | Active-low memory request strobe |
| ghost_en | input | 1 | Incomplete ROM decode mode |
| rom_cs_n | output | 1 | ROM select, active low |
| vram_cs_n | output | 1 | Video RAM select, active low |
| ram1_cs_n | output | 1 | RAM bank 1 select, active low |
| ram0_cs_n | output | 1 | RAM bank 0 select, active low |
| unmapped | output | 1 | Strobed access hit no device |

## Verification
The in-line assertions check on every cycle that at most one select is low and that the flag excludes a select. They also check that an idle strobe clears everything, that RAM bank 0 and ROM accesses select their device a cycle later, and that the ROM stays quiet outside its block when ghosting is off. Only the directed scenarios can show the exact edges of each region: the first and last address of each device and the neighbours just outside them. The same holds for the ghost image addresses, the fact that ghosting leaves device regions untouched, and the one-cycle latency against mid-cycle input changes.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    localparam int NSEL     = 4;
    localparam int SEL_ROM  = 0;
    localparam int SEL_VRAM = 1;
    localparam int SEL_RAM1 = 2;
    localparam int SEL_RAM0 = 3;

    typedef struct packed {
        logic [NSEL-1:0] cs_n;
        logic            unmapped;
    } dec_state_t;

endpackage

// File: rtl/memmap_table.sv
module memmap_table
    import memmap_pkg::*;
#(
    parameter int IDX_W     = 10,
    parameter int RAM0_BASE = 0,
    parameter int RAM0_BLKS = 64,
    parameter int RAM1_BASE = 64,
    parameter int RAM1_BLKS = 64,
    parameter int VRAM_BASE = 704,
    parameter int VRAM_BLKS = 16,
    parameter int ROM_BASE  = 1023,
    parameter int ROM_BLKS  = 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [NSEL-1:0]  sel_n
);

    localparam int DEPTH = 1 << IDX_W;

    typedef logic [NSEL-1:0] entry_t;
    typedef entry_t          tbl_t [DEPTH];

    function automatic logic in_span(int i, int base, int blks);
        return (i >= base) && (i < base + blks);
    endfunction

    function automatic entry_t entry_for(int i);
        entry_t e;
        e = '1;
        if (in_span(i, RAM0_BASE, RAM0_BLKS)) e[SEL_RAM0] = 1'b0;
        if (in_span(i, RAM1_BASE, RAM1_BLKS)) e[SEL_RAM1] = 1'b0;
        if (in_span(i, VRAM_BASE, VRAM_BLKS)) e[SEL_VRAM] = 1'b0;
        if (in_span(i, ROM_BASE,  ROM_BLKS))  e[SEL_ROM]  = 1'b0;
        return e;
    endfunction

    function automatic tbl_t build_map();
        tbl_t t;
        for (int i = 0; i < DEPTH; i++) begin
            t[i] = entry_for(i);
        end
        return t;
    endfunction

    localparam tbl_t MAP = build_map();

    assign sel_n = MAP[idx];

endmodule

// File: rtl/memmap_ghost.sv
module memmap_ghost #(
    parameter int IDX_W    = 10,
    parameter int DROP     = 2,
    parameter int ROM_BASE = 1023
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             ghost_en,
    output logic             ghost_hit
);

    localparam int KEEP = IDX_W - DROP;
    localparam logic [IDX_W-1:0] ROM_IDX = IDX_W'(ROM_BASE);
    localparam logic [KEEP-1:0]  ROM_LOW = ROM_IDX[KEEP-1:0];

    assign ghost_hit = ghost_en && (idx[KEEP-1:0] == ROM_LOW);

endmodule

// File: rtl/memmap_csel.sv
module memmap_csel
    import memmap_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int IDX_W      = 10,
    parameter int GHOST_DROP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    input  logic              ghost_en,
    output logic              rom_cs_n,
    output logic              vram_cs_n,
    output logic              ram1_cs_n,
    output logic              ram0_cs_n,
    output logic              unmapped
);

    localparam int IDX_LO = ADDR_W - IDX_W;

    logic [IDX_W-1:0] idx;
    logic [NSEL-1:0]  tbl_sel_n;
    logic             ghost_hit;
    logic [NSEL-1:0]  pat;
    dec_state_t       st_d, st_q;

    assign idx = addr[ADDR_W-1:IDX_LO];

    memmap_table #(.IDX_W(IDX_W)) u_table (
        .idx   (idx),
        .sel_n (tbl_sel_n)
    );

    memmap_ghost #(.IDX_W(IDX_W), .DROP(GHOST_DROP), .ROM_BASE((1 << IDX_W) - 1)) u_ghost (
        .idx       (idx),
        .ghost_en  (ghost_en),
        .ghost_hit (ghost_hit)
    );

    always_comb begin
        pat = tbl_sel_n;
        if ((&tbl_sel_n) && ghost_hit) begin
            pat[SEL_ROM] = 1'b0;
        end
        st_d.cs_n     = '1;
        st_d.unmapped = 1'b0;
        if (!mreq_n) begin
            st_d.cs_n     = pat;
            st_d.unmapped = &pat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_n     <= '1;
            st_q.unmapped <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rom_cs_n  = st_q.cs_n[SEL_ROM];
    assign vram_cs_n = st_q.cs_n[SEL_VRAM];
    assign ram1_cs_n = st_q.cs_n[SEL_RAM1];
    assign ram0_cs_n = st_q.cs_n[SEL_RAM0];
    assign unmapped  = st_q.unmapped;

    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rom_cs_n, vram_cs_n, ram1_cs_n, ram0_cs_n}) >= 3)
        else $error("R10 more than one select low");

    a_r10_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (rom_cs_n && vram_cs_n && ram1_cs_n && ram0_cs_n))
        else $error("R10 unmapped with select low");

    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |=> (rom_cs_n && vram_cs_n && ram1_cs_n && ram0_cs_n && !unmapped))
        else $error("R8 idle strobe left outputs active");

    a_r3_ram0: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && addr[ADDR_W-1:ADDR_W-4] == 4'h0) |=> !ram0_cs_n)
        else $error("R3 bank 0 not selected");

    a_r6_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && (&idx)) |=> !rom_cs_n)
        else $error("R6 ROM not selected");

    a_r9_no_ghost: assert property (@(posedge clk) disable iff (!rst_n)
        (!ghost_en && !(&idx)) |=> rom_cs_n)
        else $error("R9 ROM selected with ghosting off");

endmodule

// File: tb/memmap_csel_bench.sv
module memmap_csel_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        mreq_n = 1'b1;
    logic        ghost_en = 1'b0;
    logic        rom_cs_n, vram_cs_n, ram1_cs_n, ram0_cs_n, unmapped;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memmap_csel u_memmap_csel (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .ghost_en(ghost_en),
        .rom_cs_n(rom_cs_n), .vram_cs_n(vram_cs_n), .ram1_cs_n(ram1_cs_n),
        .ram0_cs_n(ram0_cs_n), .unmapped(unmapped)
    );

    // expected {rom, vram, ram1, ram0, unmapped}, from address ranges
    function automatic logic [4:0] model(logic [19:0] a, logic req_n, logic gh);
        logic [3:0] s;
        s = 4'b1111;
        if (req_n) return 5'b11110;
        if (a <= 20'h0FFFF) s = 4'b1110;
        else if (a <= 20'h1FFFF) s = 4'b1101;
        else if (a >= 20'hB0000 && a <= 20'hB3FFF) s = 4'b1011;
        else if (a >= 20'hFFC00) s = 4'b0111;
        else if (gh && a[17:10] == 8'hFF) s = 4'b0111;
        return {s, &s};
    endfunction

    function automatic logic [4:0] outs();
        return {rom_cs_n, vram_cs_n, ram1_cs_n, ram0_cs_n, unmapped};
    endfunction

    task automatic check(string tag, logic [4:0] exp);
        total++;
        if (outs() !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, outs(), exp);
        end
    endtask

    task automatic access(string tag, logic [19:0] a, logic req_n, logic gh);
        @(negedge clk);
        addr = a; mreq_n = req_n; ghost_en = gh;
        @(negedge clk);
        check(tag, model(a, req_n, gh));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #(CLK_PERIOD*2);
        check("R1 in reset", 5'b11110);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 5'b11110);
    endtask

    task automatic t_regions();
        access("R3 ram0 first", 20'h00000, 1'b0, 1'b0);
        access("R3 ram0 last",  20'h0FFFF, 1'b0, 1'b0);
        access("R4 ram1 first", 20'h10000, 1'b0, 1'b0);
        access("R4 ram1 last",  20'h1FFFF, 1'b0, 1'b0);
        access("R7 after ram1", 20'h20000, 1'b0, 1'b0);
        access("R7 before vram", 20'hAFFFF, 1'b0, 1'b0);
        access("R5 vram first", 20'hB0000, 1'b0, 1'b0);
        access("R5 vram last",  20'hB3FFF, 1'b0, 1'b0);
        access("R7 after vram", 20'hB4000, 1'b0, 1'b0);
        access("R7 before rom", 20'hFFBFF, 1'b0, 1'b0);
        access("R6 rom first",  20'hFFC00, 1'b0, 1'b0);
        access("R6 rom last",   20'hFFFFF, 1'b0, 1'b0);
        access("R7 no ghost 3FC01", 20'h3FC01, 1'b0, 1'b0);
    endtask

    task automatic t_idle();
        access("R8 idle ram0", 20'h00000, 1'b1, 1'b0);
        access("R8 idle rom",  20'hFFC00, 1'b1, 1'b1);
        access("R8 idle hole", 20'h50000, 1'b1, 1'b0);
    endtask

    task automatic t_ghost();
        access("R9 ghost 3FC01", 20'h3FC01, 1'b0, 1'b1);
        access("R9 ghost 7FC01", 20'h7FC01, 1'b0, 1'b1);
        access("R9 ghost BFC01", 20'hBFC01, 1'b0, 1'b1);
        access("R9 ghost FFC01", 20'hFFC01, 1'b0, 1'b1);
        access("R9 ghost miss 3F801", 20'h3F801, 1'b0, 1'b1);
        access("R9 ghost miss 50000", 20'h50000, 1'b0, 1'b1);
        access("R11 ghost ram0", 20'h00401, 1'b0, 1'b1);
        access("R11 ghost ram1 last", 20'h1FFFF, 1'b0, 1'b1);
        access("R11 ghost vram", 20'hB3C01, 1'b0, 1'b1);
    endtask

    task automatic t_latency();
        access("R2 settle ram0", 20'h00000, 1'b0, 1'b0);
        @(negedge clk);
        addr = 20'hFFC00;
        #(CLK_PERIOD/4);
        check("R2 no mid-cycle change", model(20'h00000, 1'b0, 1'b0));
        @(negedge clk);
        check("R2 one cycle later", model(20'hFFC00, 1'b0, 1'b0));
        // R10 check: exclusive select held across consecutive accesses
        total++;
        if ($countones({rom_cs_n, vram_cs_n, ram1_cs_n, ram0_cs_n}) < 3) begin
            bad++;
            $display("FAIL R10: selects %b expected at most one low",
                     {rom_cs_n, vram_cs_n, ram1_cs_n, ram0_cs_n});
        end
    endtask

    initial begin
        t_reset();
        t_regions();
        t_idle();
        t_ghost();
        t_latency();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule